// File: doc/BRIEF.md
# Timer Clock Source Selector

This block produces the count-enable pulse for a timer/counter, all in the system clock domain. A 3-bit select field chooses the source of the pulse. The choices are no clock, the system clock itself, four taps of a free-running 10-bit prescaler, or either edge of an asynchronous external pin. The timer advances on each clock edge at which the count-enable output is high.

The external pin passes through a synchronizer whose first stage samples on the falling clock edge. Two rising-edge stages and an edge comparison follow that stage. Detected pin edges go straight to the output and never pass through the prescaler. A synchronous prescaler-clear input restarts the prescaler at zero. Synchronous reset clears the prescaler, the synchronizer and the edge history.

The pin is sampled at the system clock rate. Detection is only guaranteed when every high and every low phase of the pin lasts longer than one clock period. Counted from the pin edge to the timer update, the latency is 2.5 to 3.5 clock cycles. Pin edges in the first two cycles after reset are not detected while the synchronizer fills.

Top module: `timer_clk_select`

## Requirements
- R1: While reset is high, `cntEn` is 0. After reset is released, the first `cntEn` pulse from a divided tap appears exactly N rising edges after the last rising edge at which reset was high, where N is the division ratio.
- R2: When `clkSel` is 000, `cntEn` stays 0 whatever `extPin` and `preClr` do.
- R3: `clkSel` 010, 011, 100 and 101 divide by 8, 64, 256 and 1024. `cntEn` is high for exactly one cycle each time the prescaler completes a period, and with `preClr` low the pulses are exactly N cycles apart.
- R4: When `clkSel` is 001, `cntEn` is high in every cycle after the first edge that samples that select value. `preClr` has no effect in this setting.
- R5: `preClr` sampled high at a rising edge sets the prescaler to zero and suppresses any divided pulse from that edge. The next divided pulse then appears exactly N edges after the clearing edge.
- R6: With `clkSel` 111, a rising level change on `extPin` that is first captured by the falling clock edge at time T makes `cntEn` high for one cycle. That cycle begins at the second rising edge after T, which puts the timer update 2.5 to 3.5 cycles after the pin edge. A falling pin change gives no pulse in this setting.
- R7: With `clkSel` 110, a falling change on `extPin` produces the same single pulse with the same timing as R6, and a rising change produces none.
- R8: In the external settings every detected pin edge gives exactly one pulse. The prescaler plays no part, so `preClr` and the prescaler count do not change pulse timing.
- R9: Changing `clkSel` between any values while `extPin` has been stable for at least two cycles creates no pulse from the external path.
- R10: If `extPin` is high when reset is released, no pulse comes out of the external path in the cycles that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| extPin | input | 1 | Asynchronous external count source |
| clkSel | input | 3 | Source select: 000 off, 001 system clock, 010 /8, 011 /64, 100 /256, 101 /1024, 110 pin falling, 111 pin rising |
| preClr | input | 1 | Synchronous prescaler clear, active high |
| cntEn | output | 1 | One-cycle count-enable pulse for the timer |

## Verification
The bench changes the pin both just before and just after a falling clock edge. This confirms the two extremes of the external latency; a design missing the half-cycle stage, or with an extra register, would be one cycle off in one of the two cases. It switches the select while the pin is held high and releases reset with the pin high. A design whose edge history is frozen or left unprimed would emit a stray count in either case. It clears the prescaler in mid-period and measures the next pulse: a clear that is ignored, or that leaks a pulse, shows up as a gap other than eight. The first-pulse position after reset and the pulse spacing at every divider catch a wrong tap or a tap that fires one count early.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int SEL_W    = 3;
  localparam int NUM_TAPS = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_OFF      = 3'b000,
    SEL_SYS      = 3'b001,
    SEL_DIV8     = 3'b010,
    SEL_DIV64    = 3'b011,
    SEL_DIV256   = 3'b100,
    SEL_DIV1024  = 3'b101,
    SEL_EXT_FALL = 3'b110,
    SEL_EXT_RISE = 3'b111
  } clkSel_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_SYS,
    SRC_TAP,
    SRC_EXT
  } srcKind_e;

  // strobes from control to datapath
  typedef struct packed {
    srcKind_e                        src;
    logic [$clog2(NUM_TAPS)-1:0]     tapIdx;
    logic                            extRise;
  } tcsStrobe_t;

  // number of low prescaler bits that must all be one for a tap to fire
  function automatic int tapWidth(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
(
  input  logic [SEL_W-1:0] clkSel,
  output tcsStrobe_t       strb
);

  clkSel_e selDec;
  assign selDec = clkSel_e'(clkSel);

  always_comb begin
    strb         = '0;
    strb.src     = SRC_NONE;
    case (selDec)
      SEL_OFF:      strb.src = SRC_NONE;
      SEL_SYS:      strb.src = SRC_SYS;
      SEL_DIV8:     begin strb.src = SRC_TAP; strb.tapIdx = 2'd0; end
      SEL_DIV64:    begin strb.src = SRC_TAP; strb.tapIdx = 2'd1; end
      SEL_DIV256:   begin strb.src = SRC_TAP; strb.tapIdx = 2'd2; end
      SEL_DIV1024:  begin strb.src = SRC_TAP; strb.tapIdx = 2'd3; end
      SEL_EXT_FALL: begin strb.src = SRC_EXT; strb.extRise = 1'b0; end
      SEL_EXT_RISE: begin strb.src = SRC_EXT; strb.extRise = 1'b1; end
      default:      strb.src = SRC_NONE;
    endcase
  end

endmodule

// File: rtl/tcs_datapath.sv
module tcs_datapath
  import tcs_pkg::*;
#(
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       extPin,
  input  logic       preClr,
  input  tcsStrobe_t strb,
  output logic       cntEn
);

  localparam int PRIME_W = $clog2(SYNC_STAGES + 1);

  // free-running prescaler
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk) begin
    if (rst || preClr) preCnt <= '0;
    else               preCnt <= preCnt + 1'b1;
  end

  // one tick per completed tap period, suppressed in a clearing cycle
  logic [NUM_TAPS-1:0] tapTick;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : gTap
    localparam int TW = tapWidth(g);
    assign tapTick[g] = (&preCnt[TW-1:0]) & ~preClr;
  end

  // pin synchronizer: half-cycle stage, then rising-edge stages
  logic                   pinNeg;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [PRIME_W-1:0]     primeCnt;
  logic                   primed;
  logic                   sNew;
  logic                   sOld;
  logic                   pinRise;
  logic                   pinFall;

  always_ff @(negedge clk) begin
    if (rst) pinNeg <= 1'b0;
    else     pinNeg <= extPin;
  end

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], pinNeg};
  end

  // edge history becomes valid once real samples fill the chain
  always_ff @(posedge clk) begin
    if (rst)          primeCnt <= '0;
    else if (!primed) primeCnt <= primeCnt + 1'b1;
  end

  assign primed  = (primeCnt == PRIME_W'(SYNC_STAGES));
  assign sNew    = syncQ[SYNC_STAGES-2];
  assign sOld    = syncQ[SYNC_STAGES-1];
  assign pinRise = primed &  sNew & ~sOld;
  assign pinFall = primed & ~sNew &  sOld;

  // source mux and output register
  logic pulseNext;

  always_comb begin
    case (strb.src)
      SRC_SYS:  pulseNext = 1'b1;
      SRC_TAP:  pulseNext = tapTick[strb.tapIdx];
      SRC_EXT:  pulseNext = strb.extRise ? pinRise : pinFall;
      default:  pulseNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cntEn <= 1'b0;
    else     cntEn <= pulseNext;
  end

endmodule

// File: rtl/timer_clk_select.sv
module timer_clk_select
  import tcs_pkg::*;
#(
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             extPin,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             preClr,
  output logic             cntEn
);

  tcsStrobe_t strb;

  tcs_ctrl uCtrl (
    .clkSel (clkSel),
    .strb   (strb)
  );

  tcs_datapath #(
    .PRE_W       (PRE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk    (clk),
    .rst    (rst),
    .extPin (extPin),
    .preClr (preClr),
    .strb   (strb),
    .cntEn  (cntEn)
  );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] clkSel,
  input logic       preClr,
  input logic       cntEn
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !cntEn); // R1

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(clkSel) == 3'b000) |-> !cntEn); // R2

  AST_TAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (cntEn && clkSel >= 3'd2 && clkSel <= 3'd5 && $stable(clkSel)) |=> !cntEn); // R3

  AST_SYS_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    ($past(clkSel) == 3'b001 && !$past(rst)) |-> cntEn); // R4

  AST_CLR_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    ($past(preClr) && $past(clkSel) >= 3'd2 && $past(clkSel) <= 3'd5) |-> !cntEn); // R5

  AST_EXT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (cntEn && clkSel >= 3'd6 && $stable(clkSel)) |=> !cntEn); // R8

endmodule

bind timer_clk_select tcs_checker uChk (
  .clk    (clk),
  .rst    (rst),
  .clkSel (clkSel),
  .preClr (preClr),
  .cntEn  (cntEn)
);

// File: tb/timer_clk_select_test.sv
module timer_clk_select_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       extPin = 1'b0;
  logic [2:0] clkSel = 3'b000;
  logic       preClr = 1'b0;
  logic       cntEn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  timer_clk_select uut (
    .clk    (clk),
    .rst    (rst),
    .extPin (extPin),
    .clkSel (clkSel),
    .preClr (preClr),
    .cntEn  (cntEn)
  );

  // select value and division ratio per divided setting
  localparam int NVEC = 5;
  localparam logic [2:0] VSEL [NVEC] = '{3'b001, 3'b010, 3'b011, 3'b100, 3'b101};
  localparam int         VDIV [NVEC] = '{1, 8, 64, 256, 1024};

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // reset held over two rising edges, released 5 ns after the last
  task automatic doReset();
    @(posedge clk); #5 rst = 1'b1;
    @(posedge clk);
    @(posedge clk); #5 rst = 1'b0;
  endtask

  // count rising edges until cntEn is seen high, sampling 2 ns after each
  task automatic waitPulse(output int k, input int limit);
    k = 0;
    do begin
      @(posedge clk); #2;
      k++;
    end while (!cntEn && k < limit);
  endtask

  // cntEn must stay low over n sampled cycles
  task automatic quiet(input string req, input int n);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      if (cntEn) highs++;
    end
    check(req, highs, 0);
  endtask

  task automatic nextSample(output logic v);
    @(posedge clk); #2;
    v = cntEn;
  endtask

  initial begin
    int k;
    logic v;

    // R1 reset state
    #2 check("R1 during reset", cntEn, 0);

    // divided and system-clock settings from the table
    for (int i = 0; i < NVEC; i++) begin
      clkSel = VSEL[i];
      doReset();
      waitPulse(k, 4000);
      check("R1 first pulse position", k, VDIV[i]);
      if (VDIV[i] == 1) begin
        int highs = 0;
        for (int j = 0; j < 20; j++) begin
          @(posedge clk); #2;
          if (cntEn) highs++;
        end
        check("R4 every cycle", highs, 20);
      end else begin
        nextSample(v);
        check("R3 one-cycle width", v, 0);
        waitPulse(k, 4000);
        check("R3 pulse spacing", k, VDIV[i] - 1);
      end
    end

    // R4 clear has no effect on system-clock setting
    @(posedge clk); #5 clkSel = 3'b001;
    @(posedge clk); #5 preClr = 1'b1;
    begin
      int highs = 0;
      for (int j = 0; j < 3; j++) begin
        @(posedge clk); #2;
        if (cntEn) highs++;
      end
      check("R4 preClr ignored", highs, 3);
    end
    #3 preClr = 1'b0;

    // R5 mid-period clear on divide by 8
    clkSel = 3'b010;
    doReset();
    waitPulse(k, 100);
    check("R5 baseline pulse", k, 8);
    @(posedge clk); @(posedge clk); #3 preClr = 1'b1;
    @(posedge clk); #5 preClr = 1'b0;
    waitPulse(k, 100);
    check("R5 gap after clear", k, 8);

    // R2 off setting ignores pin and clear
    clkSel = 3'b000;
    doReset();
    begin
      int highs = 0;
      for (int j = 0; j < 12; j++) begin
        @(posedge clk); #5 extPin = ~extPin; preClr = j[0];
        @(posedge clk); #2;
        if (cntEn) highs++;
      end
      check("R2 off stays low", highs, 0);
    end
    preClr = 1'b0;
    extPin = 1'b0;

    // R6 rising edge, change before falling edge
    clkSel = 3'b111;
    doReset();
    quiet("R6 idle", 4);
    @(posedge clk); #5 extPin = 1'b1;
    nextSample(v); check("R6 early change, E1", v, 0);
    nextSample(v); check("R6 early change, E2", v, 1);
    nextSample(v); check("R6 single cycle", v, 0);
    // falling change in rising mode
    @(posedge clk); #15 extPin = 1'b0;
    quiet("R6 falling ignored", 5);
    // rising change after the falling edge: one cycle later
    @(posedge clk); #15 extPin = 1'b1;
    nextSample(v); check("R6 late change, E1", v, 0);
    nextSample(v); check("R6 late change, E2", v, 0);
    nextSample(v); check("R6 late change, E3", v, 1);
    nextSample(v); check("R6 late single cycle", v, 0);

    // R9 select change with stable high pin
    quiet("R9 settle", 3);
    @(posedge clk); #5 clkSel = 3'b000;
    quiet("R9 to off", 3);
    @(posedge clk); #5 clkSel = 3'b110;
    quiet("R9 to falling", 3);
    @(posedge clk); #5 clkSel = 3'b111;
    quiet("R9 to rising", 3);

    // R7 falling mode
    @(posedge clk); #5 clkSel = 3'b110;
    quiet("R7 settle", 2);
    @(posedge clk); #15 extPin = 1'b0;
    nextSample(v); check("R7 falling, E1", v, 0);
    nextSample(v); check("R7 falling, E2", v, 0);
    nextSample(v); check("R7 falling, E3", v, 1);
    nextSample(v); check("R7 single cycle", v, 0);
    @(posedge clk); #5 extPin = 1'b1;
    quiet("R7 rising ignored", 5);

    // R8 every edge counted, clear plays no part
    clkSel = 3'b111;
    begin
      int pulses = 0;
      for (int e = 0; e < 10; e++) begin
        @(posedge clk); #5 extPin = ~extPin; preClr = ~preClr;
        for (int j = 0; j < 3; j++) begin
          @(posedge clk); #2;
          if (cntEn) pulses++;
        end
      end
      for (int j = 0; j < 3; j++) begin
        @(posedge clk); #2;
        if (cntEn) pulses++;
      end
      check("R8 rising edge count", pulses, 5);
    end
    preClr = 1'b0;

    // R10 pin high through reset release
    @(posedge clk); #5 extPin = 1'b1;
    doReset();
    quiet("R10 no pulse after reset", 6);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule